// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block resolves control transfers for a 32-bit core with one branch delay slot. For each retiring instruction it receives the program counter, the raw instruction word and the two source operand values. It decides whether the instruction transfers control and computes the destination address. It also reports a link write (value and destination register) and flags a misaligned register-jump target. It covers jumps through a register, with and without link, and region-absolute jumps. It also covers equality branches, signed compare-with-zero branches and the compare-with-zero group that is selected by the rt field.

A taken transfer does not redirect fetch at once. The unit remembers the destination, lets the next retiring instruction (the delay slot) complete, and raises a redirect as that instruction retires. Cycles without a retiring instruction leave the pending transfer untouched. A flush from exception handling discards a pending transfer.

Top module: `nextpc_unit`

## Requirements
- R1: For opcodes 4 to 7 and 1 (instr[31:26]), the target is pc + 4 plus the sign-extended instr[15:0] shifted left by 2.
- R2: For opcodes 2 and 3, the target is pc[31:28] concatenated with instr[25:0] and two zero bits.
- R3: The link value is pc + 8. Opcode 3 links to register 31. Opcode 0 with function instr[5:0] = 9 links to register instr[15:11].
- R4: For opcode 0 with function 8 or 9, the target is rs_val_i. If rs_val_i[1:0] is not zero, addr_err_o is high, and taken_o and link_we_o stay low.
- R5: For opcode 1, instr[16] = 0 takes the branch when rs is negative and instr[16] = 1 takes it when rs is non-negative. When instr[20:17] = 8, register 31 is linked whether or not the branch is taken. Other values of instr[20:17] give no link.
- R6: Opcode 4 is taken when rs equals rt, and opcode 5 when they differ. Opcode 6 is taken when rs, read as signed, is at most zero, and opcode 7 when it is above zero.
- R7: After a taken transfer retires, in_delay_slot_o is high. As the next retiring instruction retires, redirect_o is high and redirect_pc_o holds the saved target. Then the pending transfer ends, unless that instruction is itself taken.
- R8: A link whose destination register is 0 does not assert link_we_o.
- R9: flush_i clears any pending transfer: no redirect is raised and in_delay_slot_o is low on the following cycle.
- R10: During and right after reset no transfer is pending, so in_delay_slot_o and redirect_o are low.
- R11: Any other opcode or function is not taken and does not link. taken_o, link_we_o and addr_err_o are low whenever valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction retires this cycle |
| flush_i | input | 1 | Discard any pending transfer |
| pc_i | input | 32 | Address of the retiring instruction |
| instr_i | input | 32 | Raw instruction word |
| rs_val_i | input | 32 | Value of the rs operand |
| rt_val_i | input | 32 | Value of the rt operand |
| taken_o | output | 1 | Instruction transfers control |
| target_o | output | 32 | Computed destination address |
| link_we_o | output | 1 | Write the link value |
| link_rd_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Link value, pc + 8 |
| addr_err_o | output | 1 | Misaligned register-jump target |
| redirect_o | output | 1 | Redirect fetch as the delay slot retires |
| redirect_pc_o | output | 32 | Redirect address |
| in_delay_slot_o | output | 1 | The next retiring instruction is a delay slot |

## Verification
The hardest situation to reach is a pending transfer that meets an idle cycle, a flush, or a second taken transfer in its own delay slot. The redirect timing depends on the whole history since the transfer. The stimulus interleaves random control instructions at a high density with random idle and flush cycles. Directed sequences then place a bubble inside the slot, a flush on a pending transfer and a branch inside a delay slot. The compare-with-zero group is also driven with both link and non-link rt codes on operands at zero and at the most negative value.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned RW      = 5;
  localparam int unsigned IDX_W   = 26;
  localparam int unsigned IMM_W   = 16;
  localparam logic [RW-1:0] LINK_REG = 5'd31;

  typedef enum logic [3:0] {
    K_NONE, K_JR, K_JALR, K_J, K_JAL,
    K_BEQ, K_BNE, K_BLEZ, K_BGTZ, K_ZCMP
  } ctl_kind_e;
endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [5:0]    op_i,
  input  logic [5:0]    funct_i,
  input  logic [4:0]    rt_f_i,
  input  logic [RW-1:0] rd_f_i,
  output ctl_kind_e     kind_o,
  output logic          link_req_o,
  output logic [RW-1:0] link_rd_o
);
  always_comb begin
    kind_o = K_NONE;
    unique case (op_i)
      6'h00: begin
        if (funct_i == 6'h08)      kind_o = K_JR;
        else if (funct_i == 6'h09) kind_o = K_JALR;
      end
      6'h01: kind_o = K_ZCMP;
      6'h02: kind_o = K_J;
      6'h03: kind_o = K_JAL;
      6'h04: kind_o = K_BEQ;
      6'h05: kind_o = K_BNE;
      6'h06: kind_o = K_BLEZ;
      6'h07: kind_o = K_BGTZ;
      default: kind_o = K_NONE;
    endcase
  end

  // zero-compare group links when rt[4:1] selects the link form
  assign link_req_o = (kind_o == K_JAL) || (kind_o == K_JALR) ||
                      ((kind_o == K_ZCMP) && (rt_f_i[4:1] == 4'h8));
  assign link_rd_o  = (kind_o == K_JALR) ? rd_f_i : LINK_REG;
endmodule

// File: rtl/nextpc_eval.sv
module nextpc_eval
  import nextpc_pkg::*;
(
  input  ctl_kind_e     kind_i,
  input  logic          ge_sel_i,
  input  logic [AW-1:0] rs_val_i,
  input  logic [AW-1:0] rt_val_i,
  output logic          is_ctl_o,
  output logic          cond_o
);
  logic rs_neg, rs_zero, eq;

  assign rs_neg  = rs_val_i[AW-1];
  assign rs_zero = (rs_val_i == '0);
  assign eq      = (rs_val_i == rt_val_i);

  always_comb begin
    is_ctl_o = 1'b1;
    cond_o   = 1'b1;
    unique case (kind_i)
      K_BEQ:  cond_o = eq;
      K_BNE:  cond_o = !eq;
      K_BLEZ: cond_o = rs_neg || rs_zero;
      K_BGTZ: cond_o = !rs_neg && !rs_zero;
      K_ZCMP: cond_o = ge_sel_i ? !rs_neg : rs_neg;
      K_JR, K_JALR, K_J, K_JAL: cond_o = 1'b1;
      default: begin
        is_ctl_o = 1'b0;
        cond_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
(
  input  ctl_kind_e        kind_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    rs_val_i,
  output logic [AW-1:0]    target_o,
  output logic [AW-1:0]    link_val_o,
  output logic             misalign_o
);
  localparam int unsigned REGION_W = AW - IDX_W - 2;

  logic [IMM_W-1:0] imm;
  logic [AW-1:0]    rel_off;
  logic             reg_jump;

  assign imm      = idx_i[IMM_W-1:0];
  assign rel_off  = {{(AW-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign reg_jump = (kind_i == K_JR) || (kind_i == K_JALR);

  always_comb begin
    if (reg_jump)
      target_o = rs_val_i;
    else if ((kind_i == K_J) || (kind_i == K_JAL))
      target_o = {pc_i[AW-1 -: REGION_W], idx_i, 2'b00};
    else
      target_o = pc_i + AW'(4) + rel_off;
  end

  assign link_val_o = pc_i + AW'(8);
  assign misalign_o = reg_jump && (rs_val_i[1:0] != 2'b00);
endmodule

// File: rtl/nextpc_slot.sv
module nextpc_slot
  import nextpc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          flush_i,
  input  logic          taken_i,
  input  logic [AW-1:0] target_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          pending_o
);
  logic          pend_q;
  logic [AW-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (flush_i) begin
      pend_q <= 1'b0;
    end else if (valid_i) begin
      pend_q <= taken_i;
      if (taken_i) tgt_q <= target_i;
    end
  end

  assign redirect_o    = valid_i && pend_q && !flush_i;
  assign redirect_pc_o = tgt_q;
  assign pending_o     = pend_q;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          flush_i,
  input  logic [31:0]   pc_i,
  input  logic [31:0]   instr_i,
  input  logic [31:0]   rs_val_i,
  input  logic [31:0]   rt_val_i,
  output logic          taken_o,
  output logic [31:0]   target_o,
  output logic          link_we_o,
  output logic [4:0]    link_rd_o,
  output logic [31:0]   link_val_o,
  output logic          addr_err_o,
  output logic          redirect_o,
  output logic [31:0]   redirect_pc_o,
  output logic          in_delay_slot_o
);
  ctl_kind_e     kind;
  logic          link_req, is_ctl, cond, misalign;
  logic [RW-1:0] lrd;

  nextpc_decode u_dec (
    .op_i       (instr_i[31:26]),
    .funct_i    (instr_i[5:0]),
    .rt_f_i     (instr_i[20:16]),
    .rd_f_i     (instr_i[15:11]),
    .kind_o     (kind),
    .link_req_o (link_req),
    .link_rd_o  (lrd)
  );

  nextpc_eval u_eval (
    .kind_i   (kind),
    .ge_sel_i (instr_i[16]),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .is_ctl_o (is_ctl),
    .cond_o   (cond)
  );

  nextpc_target u_tgt (
    .kind_i     (kind),
    .pc_i       (pc_i),
    .idx_i      (instr_i[IDX_W-1:0]),
    .rs_val_i   (rs_val_i),
    .target_o   (target_o),
    .link_val_o (link_val_o),
    .misalign_o (misalign)
  );

  assign taken_o    = valid_i && is_ctl && cond && !misalign;
  assign addr_err_o = valid_i && misalign;
  assign link_we_o  = valid_i && link_req && !misalign && (lrd != '0);
  assign link_rd_o  = lrd;

  nextpc_slot u_slot (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .flush_i       (flush_i),
    .taken_i       (taken_o),
    .target_i      (target_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .pending_o     (in_delay_slot_o)
  );
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        flush_i,
  input logic [31:0] pc_i,
  input logic        taken_o,
  input logic [31:0] target_o,
  input logic        link_we_o,
  input logic [4:0]  link_rd_o,
  input logic [31:0] link_val_o,
  input logic        addr_err_o,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic        in_delay_slot_o
);
  logic [31:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cap_q <= '0;
    else if (valid_i && taken_o && !flush_i)    cap_q <= target_o;
  end

  a_r7_slot_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && taken_o && !flush_i) |=> in_delay_slot_o);

  a_r7_redirect_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (redirect_pc_o == cap_q));

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !flush_i) |=> (in_delay_slot_o == $past(in_delay_slot_o)));

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !in_delay_slot_o);

  a_r4_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (!taken_o && !link_we_o));

  a_r8_no_reg0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_rd_o != 5'd0));

  a_r3_link_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_val_o == pc_i + 32'd8));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!taken_o && !link_we_o && !addr_err_o && !redirect_o));
endmodule

bind nextpc_unit nextpc_unit_chk i_chk (.*);

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, flush = 1'b0;
  logic [31:0] pc = '0, instr = '0, rs_v = '0, rt_v = '0;
  logic        taken, link_we, addr_err, redirect, in_slot;
  logic [31:0] target, link_val, redirect_pc;
  logic [4:0]  link_rd;

  int n_tests = 0, n_fail = 0;
  bit exp_pend = 1'b0;
  logic [31:0] exp_tgt = '0;
  string slot_tag = "R7";

  always #10 clk = ~clk;

  nextpc_unit i_nextpc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .flush_i(flush),
    .pc_i(pc), .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
    .taken_o(taken), .target_o(target), .link_we_o(link_we),
    .link_rd_o(link_rd), .link_val_o(link_val), .addr_err_o(addr_err),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .in_delay_slot_o(in_slot)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit v, input logic [31:0] p, input logic [31:0] ins,
                       input logic [31:0] rs, input logic [31:0] rt,
                       output bit tk, output logic [31:0] tg, output bit we,
                       output logic [4:0] lrd, output bit err,
                       output string ctag, output string ttag, output string ltag);
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    logic [31:0] rel = p + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    bit ctl = 1'b1, cond = 1'b1, lreq = 1'b0;
    bit rjump = (op == 6'd0) && (fn == 6'd8 || fn == 6'd9);
    bit neg = rs[31];
    lrd = 5'd31; tg = rel; ttag = "R1"; ctag = "R6";
    case (op)
      6'd0: begin
        ctl = rjump; tg = rs; ttag = "R4"; ctag = rjump ? "R4" : "R11";
        if (fn == 6'd9) begin lreq = 1'b1; lrd = ins[15:11]; end
      end
      6'd1: begin
        cond = ins[16] ? !neg : neg; ctag = "R5";
        lreq = (ins[20:17] == 4'h8);
      end
      6'd2, 6'd3: begin
        tg = {p[31:28], ins[25:0], 2'b00}; ttag = "R2"; ctag = "R2";
        lreq = (op == 6'd3);
      end
      6'd4: cond = (rs == rt);
      6'd5: cond = (rs != rt);
      6'd6: cond = neg || (rs == 0);
      6'd7: cond = !neg && (rs != 0);
      default: begin ctl = 1'b0; ctag = "R11"; end
    endcase
    if (!ctl) cond = 1'b0;
    err = v && rjump && (rs[1:0] != 2'b00);
    tk  = v && ctl && cond && !err;
    we  = v && lreq && !err && (lrd != 5'd0);
    if (!v) ctag = "R11";
    ltag = !lreq ? "R11" : (lrd == 5'd0) ? "R8" : (op == 6'd1) ? "R5" : "R3";
  endtask

  task automatic step(input bit v, input bit f, input logic [31:0] p,
                      input logic [31:0] ins, input logic [31:0] rs,
                      input logic [31:0] rt);
    bit tk, we, err;
    logic [31:0] tg;
    logic [4:0] lrd;
    string ct, tt, lt;
    @(negedge clk);
    valid = v; flush = f; pc = p; instr = ins; rs_v = rs; rt_v = rt;
    #2;
    model(v, p, ins, rs, rt, tk, tg, we, lrd, err, ct, tt, lt);
    chk(ct, "taken", {31'd0, taken}, {31'd0, tk});
    chk(err ? "R4" : ct, "addr_err", {31'd0, addr_err}, {31'd0, err});
    if (tk) chk(tt, "target", target, tg);
    chk(lt, "link_we", {31'd0, link_we}, {31'd0, we});
    if (we) begin
      chk(lt, "link_val", link_val, p + 32'd8);
      chk(lt, "link_rd", {27'd0, link_rd}, {27'd0, lrd});
    end
    chk(slot_tag, "in_slot", {31'd0, in_slot}, {31'd0, exp_pend});
    chk(slot_tag, "redirect", {31'd0, redirect}, {31'd0, v && exp_pend && !f});
    if (v && exp_pend && !f) chk(slot_tag, "redirect_pc", redirect_pc, exp_tgt);
    @(posedge clk);
    if (f) exp_pend = 1'b0;
    else if (v) begin
      exp_pend = tk;
      if (tk) exp_tgt = tg;
    end
  endtask

  function automatic logic [31:0] rnd_instr();
    logic [31:0] w = $urandom;
    case ($urandom % 12)
      0:  return {6'd0, w[25:6], 6'd8};
      1:  return {6'd0, w[25:6], 6'd9};
      2:  return {6'd2, w[25:0]};
      3:  return {6'd3, w[25:0]};
      4, 5, 6, 7: return {6'd4 + 6'(w[27:26]), w[25:0]};
      8:  return {6'd1, w[25:0]};
      9:  return {6'd1, w[25:21], 4'h8, w[16:0]};
      10: return {6'd0, w[25:6], 6'h21};
      default: return {6'd8 + 6'(w[29:26]), w[25:0]};
    endcase
  endfunction

  function automatic logic [31:0] rnd_val(input logic [31:0] other);
    case ($urandom % 6)
      0: return 32'd0;
      1: return other;
      2: return 32'h8000_0000;
      3: return {$urandom, 2'b00};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R10: reset state
    valid = 1'b1;
    #15;
    chk("R10", "in_slot reset", {31'd0, in_slot}, 32'd0);
    chk("R10", "redirect reset", {31'd0, redirect}, 32'd0);
    @(negedge clk); rst_n = 1'b1; valid = 1'b0;
    #2;
    chk("R10", "in_slot after reset", {31'd0, in_slot}, 32'd0);

    // R1 + R6: backward BEQ taken, then delay slot redirect (R7)
    step(1, 0, 32'h8001_0000, {6'd4, 5'd1, 5'd2, 16'hFFFC}, 32'd5, 32'd5);
    step(0, 0, 32'h0, 32'h0, 32'h0, 32'h0);  // bubble keeps pending
    step(1, 0, 32'h8001_0004, 32'h0000_0021, 32'h1, 32'h2);
    // R2: absolute jump keeps region bits
    step(1, 0, 32'hA123_4560, {6'd2, 26'h3FF_FFFF}, 32'h0, 32'h0);
    step(1, 0, 32'hA123_4564, 32'h0, 32'h0, 32'h0);
    // R3: jump-and-link, register-jump-and-link to rd 7
    step(1, 0, 32'h0000_1000, {6'd3, 26'h0000_040}, 32'h0, 32'h0);
    step(1, 0, 32'h0000_1004, {6'd0, 5'd3, 5'd0, 5'd7, 5'd0, 6'd9}, 32'h0000_2000, 32'h0);
    // R8: link to register 0 suppressed
    step(1, 0, 32'h0000_2000, {6'd0, 5'd3, 5'd0, 5'd0, 5'd0, 6'd9}, 32'h0000_3000, 32'h0);
    // R4: misaligned register jump, no redirect follows
    step(1, 0, 32'h0000_3000, {6'd0, 5'd3, 5'd0, 5'd31, 5'd0, 6'd9}, 32'h0000_4002, 32'h0);
    step(1, 0, 32'h0000_3000, {6'd0, 5'd3, 15'd0, 6'd8}, 32'h0000_4001, 32'h0);
    step(1, 0, 32'h0000_3004, 32'h0, 32'h0, 32'h0);
    // R5: link form not taken still links; non-link code 9 does not
    step(1, 0, 32'h0000_5000, {6'd1, 5'd2, 5'h10, 16'h0010}, 32'h0000_0001, 32'h0);
    step(1, 0, 32'h0000_5004, {6'd1, 5'd2, 5'h13, 16'h0010}, 32'h0000_0000, 32'h0);
    step(1, 0, 32'h0000_5008, {6'd1, 5'd2, 5'h12, 16'h0010}, 32'h0000_0000, 32'h0);
    // R6: most negative value on BLEZ/BGTZ
    step(1, 0, 32'h0000_6000, {6'd6, 5'd2, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0);
    step(1, 0, 32'h0000_6004, {6'd7, 5'd2, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0);
    step(1, 0, 32'h0000_6008, {6'd7, 5'd2, 5'd0, 16'h0004}, 32'h0000_0000, 32'h0);
    // R7: taken branch inside a delay slot
    step(1, 0, 32'h0000_7000, {6'd5, 5'd1, 5'd2, 16'h0040}, 32'h1, 32'h2);
    step(1, 0, 32'h0000_7004, {6'd2, 26'h0000_100}, 32'h0, 32'h0);
    step(1, 0, 32'h0000_7104, 32'h0, 32'h0, 32'h0);
    step(1, 0, 32'h0000_0400, 32'h0, 32'h0, 32'h0);
    // R9: flush discards a pending transfer
    step(1, 0, 32'h0000_8000, {6'd2, 26'h0000_200}, 32'h0, 32'h0);
    slot_tag = "R9";
    step(0, 1, 32'h0, 32'h0, 32'h0, 32'h0);
    step(1, 0, 32'h0000_8004, 32'h0, 32'h0, 32'h0);
    slot_tag = "R7";
    // R11: idle cycle with a control instruction on the bus
    step(0, 0, 32'h0000_9000, {6'd3, 26'h1}, 32'h0, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a = rnd_val(32'h1234_5678);
      logic [31:0] b = rnd_val(a);
      bit v = ($urandom % 8) != 0;
      bit f = ($urandom % 16) == 0;
      step(v, f, {$urandom, 2'b00}, rnd_instr(), a, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule